// File: doc/BRIEF.md
# Pulse-Pause Reader Bit Encoder

This block turns a frame of reader-to-tag bits into the on/off enable for the reader's carrier. Every bit is sent with pulse-pause coding. The carrier first drops for a fixed pause, then comes back on for an interval whose length depends on the bit value: a one keeps the carrier on longer than a zero. All timing is expressed in ticks of a slow timebase. The block derives this timebase from its own clock by a fixed division and exposes the running tick count, so a receive path can share it.

A frame is offered as a bit count plus a data word on a valid/ready handshake. The block keeps one timestamp, in ticks, of the moment the most recent frame ended. That frame may be a tag frame, announced by a strobe from the receive path, or a frame this block sent itself. The block accepts no new frame until a minimum gap has passed since that timestamp. When the last carrier-on interval of a frame ends, the block pulses a completion output and writes the current tick count into the timestamp.

In the default setting the clock is divided by 32 to form the tick. The pause is 30 ticks. A one is on for 120 ticks and a zero for 60 ticks. The minimum gap is 330 ticks.

Top module: `pp_bit_encoder`

## Requirements
- R1: `now_ticks` is 0 after reset and increases by exactly 1 every CLKS_PER_TICK clocks.
- R2: After reset, `carrier_en` is 1, `done` is 0 and `last_end_ts` is 0. `carrier_en` is 1 whenever the block is idle.
- R3: `in_ready` is 1 only when the block is idle, `rx_end` is 0, and `now_ticks - last_end_ts` (modulo 2^TS_W) is at least GAP_TICKS. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both 1.
- R4: Every bit starts with PAUSE_TICKS*CLKS_PER_TICK clocks of `carrier_en` = 0. The first pause begins in the clock cycle right after the accepting edge.
- R5: After its pause, a bit whose value is 1 holds `carrier_en` = 1 for ONE_ON_TICKS*CLKS_PER_TICK clocks. A bit whose value is 0 holds it for ZERO_ON_TICKS*CLKS_PER_TICK clocks.
- R6: Bits go out least significant first. Bit i of the frame is `in_data[i]`, and exactly as many bits are sent as the effective bit count.
- R7: `done` is 1 for exactly one clock cycle, the cycle that follows the last carrier-on interval. In that cycle `last_end_ts` equals the `now_ticks` value of the previous cycle.
- R8: A frame with `in_nbits` = 0 produces no pause. `done` is 1 in the cycle right after the accepting edge.
- R9: While `rx_end` is 1, no frame is accepted. On the next edge `last_end_ts` takes the current `now_ticks`, which restarts the gap.
- R10: Changes on `in_data` and `in_nbits` after the accepting edge do not alter the frame being sent.
- R11: A value of `in_nbits` above MAX_BITS is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Frame can be accepted this cycle |
| in_nbits | input | $clog2(MAX_BITS+1) | Number of bits in the frame |
| in_data | input | MAX_BITS | Frame bits, bit 0 sent first |
| rx_end | input | 1 | Strobe: a received tag frame ended now |
| carrier_en | output | 1 | Carrier enable, 0 during pauses |
| done | output | 1 | One-cycle pulse at the end of a frame |
| now_ticks | output | TS_W | Running tick count |
| last_end_ts | output | TS_W | Tick count at the end of the latest frame |

## Verification
Two collisions are provoked on purpose. In the first, `rx_end` arrives in the same cycle that a pending frame would have been accepted. The bench raises `in_valid` and `rx_end` together on a cycle where `in_ready` was already 1. The pass condition is that the carrier stays on (nothing was accepted), `in_ready` falls, and the timestamp takes the tick value of that cycle. In the second, frame completion and the timestamp update fall on the same edge. Each `done` cycle is checked against the tick count sampled one cycle earlier, and the wait before the next frame is checked against the gap on every cycle.

// File: rtl/pp_bit_encoder.sv
module pp_bit_encoder #(
  parameter int CLKS_PER_TICK = 32,
  parameter int PAUSE_TICKS   = 30,
  parameter int ONE_ON_TICKS  = 120,
  parameter int ZERO_ON_TICKS = 60,
  parameter int GAP_TICKS     = 330,
  parameter int MAX_BITS      = 32,
  parameter int TS_W          = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [$clog2(MAX_BITS+1)-1:0] in_nbits,
  input  logic [MAX_BITS-1:0]           in_data,
  input  logic                          rx_end,
  output logic                          carrier_en,
  output logic                          done,
  output logic [TS_W-1:0]               now_ticks,
  output logic [TS_W-1:0]               last_end_ts
);
  localparam int NB_W      = $clog2(MAX_BITS+1);
  localparam int PRE_W     = $clog2(CLKS_PER_TICK+1);
  localparam int PAUSE_CLK = PAUSE_TICKS * CLKS_PER_TICK;
  localparam int ONE_CLK   = ONE_ON_TICKS * CLKS_PER_TICK;
  localparam int ZERO_CLK  = ZERO_ON_TICKS * CLKS_PER_TICK;
  localparam int MAX_CLK   = (ONE_CLK > PAUSE_CLK) ? ONE_CLK : PAUSE_CLK;
  localparam int DUR_W     = $clog2(MAX_CLK+1);

  typedef enum logic [1:0] {S_IDLE, S_PAUSE, S_ON} st_t;

  st_t                st;
  logic [PRE_W-1:0]   pre;
  logic [TS_W-1:0]    now_q, last_q;
  logic [DUR_W-1:0]   cnt;
  logic [MAX_BITS-1:0] sh;
  logic [NB_W-1:0]    left;
  logic               done_q;

  wire [TS_W-1:0] elapsed = now_q - last_q;
  wire            gap_ok  = elapsed >= TS_W'(GAP_TICKS);
  wire [NB_W-1:0] nb_eff  = (in_nbits > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : in_nbits;
  wire            accept;
  wire            last_on = (st == S_ON) && (cnt == '0) && (left == NB_W'(1));
  wire            fin     = last_on || (accept && nb_eff == '0);

  assign in_ready    = (st == S_IDLE) && gap_ok && !rx_end;
  assign accept      = in_valid && in_ready;
  assign carrier_en  = (st != S_PAUSE);
  assign done        = done_q;
  assign now_ticks   = now_q;
  assign last_end_ts = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      now_q <= '0;
    end else if (pre == PRE_W'(CLKS_PER_TICK-1)) begin
      pre   <= '0;
      now_q <= now_q + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (rx_end || fin) last_q <= now_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sh   <= '0;
      left <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && nb_eff != '0) begin
          sh   <= in_data;
          left <= nb_eff;
          cnt  <= DUR_W'(PAUSE_CLK-1);
          st   <= S_PAUSE;
        end
        S_PAUSE: if (cnt == '0) begin
          cnt <= sh[0] ? DUR_W'(ONE_CLK-1) : DUR_W'(ZERO_CLK-1);
          st  <= S_ON;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_ON: if (cnt == '0) begin
          if (left == NB_W'(1)) begin
            st <= S_IDLE;
          end else begin
            sh   <= sh >> 1;
            left <= left - 1'b1;
            cnt  <= DUR_W'(PAUSE_CLK-1);
            st   <= S_PAUSE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (now_ticks == $past(now_ticks) || now_ticks == $past(now_ticks) + 1'b1));
  // R2
  idle_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> carrier_en);
  // R4
  first_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && nb_eff != '0) |=> !carrier_en);
  // R7
  done_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> last_end_ts == $past(now_ticks));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && nb_eff == '0) |=> (done && carrier_en));
  // R9
  rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> (!in_ready && last_end_ts == $past(now_ticks)));
endmodule

// File: tb/sim_pp_bit_encoder.sv
module sim_pp_bit_encoder;
  localparam int CPT = 2, PT = 3, OT = 4, ZT = 2, GT = 10, MB = 8, TW = 16;
  localparam int PC = PT*CPT, OC = OT*CPT, ZC = ZT*CPT;

  logic clk = 0, rst_n = 0, in_valid = 0, rx_end = 0;
  logic [3:0] in_nbits = 0;
  logic [7:0] in_data = 0;
  logic in_ready, carrier_en, done;
  logic [TW-1:0] now_ticks, last_end_ts;
  int checks = 0, failures = 0, cyc = 0;

  pp_bit_encoder #(.CLKS_PER_TICK(CPT), .PAUSE_TICKS(PT), .ONE_ON_TICKS(OT),
    .ZERO_ON_TICKS(ZT), .GAP_TICKS(GT), .MAX_BITS(MB), .TS_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_nbits(in_nbits), .in_data(in_data), .rx_end(rx_end),
    .carrier_en(carrier_en), .done(done), .now_ticks(now_ticks),
    .last_end_ts(last_end_ts));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [TW-1:0] prev_now;

  task automatic wait_ready();
    int bad = 0;
    @(negedge clk);
    while (!in_ready) begin
      if ((TW'(now_ticks - last_end_ts) >= GT) && carrier_en) bad++;
      @(negedge clk);
    end
    if (TW'(now_ticks - last_end_ts) < GT) bad++;
    check(bad == 0, "R3 gap gating", bad, 0);
  endtask

  task automatic run_frame(input int n, input logic [7:0] d);
    int eff = (n > MB) ? MB : n;
    int bad = 0;
    wait_ready();
    prev_now = now_ticks;
    in_nbits = 4'(n); in_data = d; in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0; in_nbits = ~in_nbits; in_data = ~d;
    @(negedge clk);
    for (int i = 0; i < eff; i++) begin
      for (int k = 0; k < PC; k++) begin
        if (carrier_en !== 1'b0 || done !== 1'b0) bad++;
        prev_now = now_ticks; @(negedge clk);
      end
      for (int k = 0; k < (d[i] ? OC : ZC); k++) begin
        if (carrier_en !== 1'b1 || done !== 1'b0) bad++;
        prev_now = now_ticks; @(negedge clk);
      end
    end
    // R4 R5 R6 R10 R11
    check(bad == 0, "R5 R6 R10 waveform", bad, 0);
    if (n == 0) check(done === 1'b1 && carrier_en === 1'b1, "R8 empty frame", done, 1);
    check(done === 1'b1 && last_end_ts == prev_now, "R7 done stamp", last_end_ts, prev_now);
    @(negedge clk);
    check(done === 1'b0, "R7 done width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(carrier_en === 1 && done === 0 && last_end_ts == 0, "R2 reset", carrier_en, 1);
    check(in_ready === 0, "R2 ready low at reset", in_ready, 0);

    begin
      int bad = 0, run = 0;
      logic [TW-1:0] p = now_ticks;
      while (now_ticks == p) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
        p = now_ticks; run = 0;
        while (now_ticks == p) begin run++; @(negedge clk); end
        if (run != CPT || now_ticks != p + 1) bad++;
      end
      check(bad == 0, "R1 tick rate", bad, 0);
    end

    run_frame(0, 8'h5A);
    foreach (in_data[b]) run_frame(1, 8'(b));
    for (int n = 1; n <= MB; n++)
      for (int pi = 0; pi < 6; pi++)
        run_frame(n, (pi == 0) ? 8'h00 : (pi == 1) ? 8'hFF : (pi == 2) ? 8'hA5 :
                     (pi == 3) ? 8'h5A : (pi == 4) ? 8'h01 : 8'h80);
    for (int v = 0; v < 256; v++) run_frame(MB, 8'(v));
    // R11 oversize count
    run_frame(12, 8'hC3);
    run_frame(15, 8'h3C);

    // R9 rx_end collides with a pending accept
    wait_ready();
    prev_now = now_ticks;
    in_valid = 1; in_nbits = 4'd3; in_data = 8'h07; rx_end = 1;
    @(posedge clk); #1;
    rx_end = 0; in_valid = 0;
    @(negedge clk);
    check(carrier_en === 1'b1, "R9 no accept under rx_end", carrier_en, 1);
    check(in_ready === 1'b0, "R9 ready dropped", in_ready, 0);
    check(last_end_ts == prev_now, "R9 stamp loaded", last_end_ts, prev_now);
    run_frame(3, 8'h05);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule